// File: doc/BRIEF.md
# DMA Channel Run Control

This block governs whether one DMA channel is stopped, running or paused, and it keeps the element transfer counter of that channel. Software writes a 2-bit command. The resulting state appears on a 2-bit status output on the next clock edge. That state, together with the element-done strobe from the data mover, decides how the counter advances.

A start issued from the stopped state loads the counter from one of two shared reload values, picked by a select bit. The same reload path refills the counter at the end of each block when autoinitialization is active, so repeated and multi-block transfers run without software stepping in. When a block ends without autoinitialization, the channel stops on its own and pulses a done flag. Address generation, data movement, interrupts and frame structure belong to other blocks.

Top module: `chan_run_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, the block sets `status` to 00, `count` to 0 and `done` to 0.
- R2: When `cmd_wr` is sampled high, `status` takes the commanded state at that edge. The command and status codes are: 00 stop, 01 run without autoinitialization, 10 pause, 11 run with autoinitialization.
- R3: A start command (01 or 11) given while the channel is stopped loads `count` with `rld_a` when `rld_sel` is 0, and with `rld_b` when `rld_sel` is 1.
- R4: In a running state (01 or 11), an `elem_done` strobe with `count` greater than 1 lowers `count` by exactly one at that edge.
- R5: In state 01, an `elem_done` strobe with `count` at 1 or 0 ends the block at that edge. `status` becomes 00, `count` becomes 0, and `done` is high for exactly that one cycle.
- R6: In state 11, an `elem_done` strobe with `count` at 1 or 0 reloads `count` from the register that `rld_sel` picks at that edge. `status` stays 11 and `done` stays low.
- R7: A pause command moves a running channel to 10. In state 10, `count` holds and `elem_done` has no effect. A pause command while stopped leaves `status` at 00.
- R8: A start command given while paused resumes in the commanded mode (01 or 11) with `count` unchanged.
- R9: A stop command sets `status` to 00 at the next edge. After that, `count` keeps its last value until the next start.
- R10: When `cmd_wr` and `elem_done` are high in the same cycle, the command applies and the strobe is dropped, so `count` does not decrement.
- R11: A start command given while already running changes only the mode, and `count` holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr | input | 1 | Command write strobe |
| cmd | input | 2 | Run command code |
| elem_done | input | 1 | One element transferred |
| rld_sel | input | 1 | Reload source select (0: A, 1: B) |
| rld_a | input | CNT_W | Shared count reload value A |
| rld_b | input | CNT_W | Shared count reload value B |
| status | output | 2 | Current run state code |
| count | output | CNT_W | Element transfer counter |
| done | output | 1 | One-cycle end-of-block pulse without autoinitialization |

## Verification
A wrong run state appears on `status` at the very next edge, because the state register drives that port directly. A miscounted or wrongly reloaded counter appears on `count` at the edge that follows the faulty strobe or command. The bench compares a behavioural model against every output on every cycle, so any divergence in state or count is reported in the cycle it occurs rather than later. An error in the end-of-block logic shows up either as a missing or doubled `done` pulse or as a channel that keeps running after its final element.

// File: rtl/chan_run_pkg.sv
package chan_run_pkg;

    typedef enum logic [1:0] {
        RS_STOP     = 2'b00,
        RS_RUN      = 2'b01,
        RS_PAUSE    = 2'b10,
        RS_RUN_AUTO = 2'b11
    } run_state_e;

    typedef enum logic [1:0] {
        CNT_HOLD = 2'b00,
        CNT_LOAD = 2'b01,
        CNT_DEC  = 2'b10,
        CNT_CLR  = 2'b11
    } cnt_op_e;

    function automatic logic is_active(input run_state_e s);
        return (s == RS_RUN) || (s == RS_RUN_AUTO);
    endfunction

endpackage

// File: rtl/chan_run_fsm.sv
module chan_run_fsm
    import chan_run_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       cmd_wr,
    input  logic [1:0] cmd,
    input  logic       elem_done,
    input  logic       cnt_last,
    output run_state_e state,
    output cnt_op_e    cnt_op,
    output logic       done
);

    run_state_e nxt_state;
    logic       nxt_done;
    run_state_e cmd_state;

    assign cmd_state = run_state_e'(cmd);

    always_comb begin
        nxt_state = state;
        cnt_op    = CNT_HOLD;
        nxt_done  = 1'b0;
        if (cmd_wr) begin
            case (cmd_state)
                RS_STOP:  nxt_state = RS_STOP;
                RS_PAUSE: if (is_active(state)) nxt_state = RS_PAUSE;
                default: begin
                    if (state == RS_STOP) cnt_op = CNT_LOAD;
                    nxt_state = cmd_state;
                end
            endcase
        end else if (elem_done && is_active(state)) begin
            if (cnt_last) begin
                if (state == RS_RUN_AUTO) begin
                    cnt_op = CNT_LOAD;
                end else begin
                    cnt_op    = CNT_CLR;
                    nxt_state = RS_STOP;
                    nxt_done  = 1'b1;
                end
            end else begin
                cnt_op = CNT_DEC;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RS_STOP;
            done  <= 1'b0;
        end else begin
            state <= nxt_state;
            done  <= nxt_done;
        end
    end

    AST_DONE_STOPPED: assert property (@(posedge clk) disable iff (rst)
        done |-> state == RS_STOP); // R5
    AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst)
        done |=> !done); // R5
    AST_AUTO_KEEP: assert property (@(posedge clk) disable iff (rst)
        (state == RS_RUN_AUTO && !cmd_wr) |=> state == RS_RUN_AUTO); // R6
    AST_STOP_CMD: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd == 2'b00) |=> state == RS_STOP); // R9
    AST_PAUSE_IDLE: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd == 2'b10 && state == RS_STOP) |=> state == RS_STOP); // R7

endmodule

// File: rtl/chan_xfer_cnt.sv
module chan_xfer_cnt
    import chan_run_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  cnt_op_e          cnt_op,
    input  logic             rld_sel,
    input  logic [CNT_W-1:0] rld_a,
    input  logic [CNT_W-1:0] rld_b,
    output logic [CNT_W-1:0] count,
    output logic             cnt_last
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] rld_val;

    assign rld_val  = rld_sel ? rld_b : rld_a;
    assign cnt_last = (count <= ONE);

    always_ff @(posedge clk) begin
        if (rst) begin
            count <= '0;
        end else begin
            case (cnt_op)
                CNT_LOAD: count <= rld_val;
                CNT_DEC:  count <= count - ONE;
                CNT_CLR:  count <= '0;
                default:  count <= count;
            endcase
        end
    end

    AST_LOAD_SRC: assert property (@(posedge clk) disable iff (rst)
        (cnt_op == CNT_LOAD) |=> count == (($past(rld_sel)) ? $past(rld_b) : $past(rld_a))); // R3

endmodule

// File: rtl/chan_run_ctrl.sv
module chan_run_ctrl
    import chan_run_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cmd_wr,
    input  logic [1:0]       cmd,
    input  logic             elem_done,
    input  logic             rld_sel,
    input  logic [CNT_W-1:0] rld_a,
    input  logic [CNT_W-1:0] rld_b,
    output logic [1:0]       status,
    output logic [CNT_W-1:0] count,
    output logic             done
);

    run_state_e state;
    cnt_op_e    cnt_op;
    logic       cnt_last;

    chan_run_fsm u_fsm (
        .clk       (clk),
        .rst       (rst),
        .cmd_wr    (cmd_wr),
        .cmd       (cmd),
        .elem_done (elem_done),
        .cnt_last  (cnt_last),
        .state     (state),
        .cnt_op    (cnt_op),
        .done      (done)
    );

    chan_xfer_cnt #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst      (rst),
        .cnt_op   (cnt_op),
        .rld_sel  (rld_sel),
        .rld_a    (rld_a),
        .rld_b    (rld_b),
        .count    (count),
        .cnt_last (cnt_last)
    );

    assign status = state;

    AST_PAUSE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b10 && !cmd_wr) |=> $stable(count)); // R7
    AST_STOP_KEEP: assert property (@(posedge clk) disable iff (rst)
        (status == 2'b00 && !cmd_wr) |=> $stable(count)); // R9
    AST_DEC_ONE: assert property (@(posedge clk) disable iff (rst)
        (status[0] && elem_done && !cmd_wr && count > CNT_W'(1)) |=> count == $past(count) - CNT_W'(1)); // R4
    AST_CMD_WINS: assert property (@(posedge clk) disable iff (rst)
        (cmd_wr && cmd[0] && status[0]) |=> $stable(count)); // R10

endmodule

// File: tb/chan_run_ctrl_tb.sv
module chan_run_ctrl_tb;

    localparam int CNT_W = 16;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cmd_wr = 1'b0;
    logic [1:0]       cmd = 2'b00;
    logic             elem_done = 1'b0;
    logic             rld_sel = 1'b0;
    logic [CNT_W-1:0] rld_a = '0;
    logic [CNT_W-1:0] rld_b = '0;
    logic [1:0]       status;
    logic [CNT_W-1:0] count;
    logic             done;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    string cur_req = "R1";

    int m_st = 0;
    int m_cnt = 0;
    int m_done = 0;

    always #2 clk = ~clk;

    chan_run_ctrl #(.CNT_W(CNT_W)) u_dut (
        .clk(clk), .rst(rst), .cmd_wr(cmd_wr), .cmd(cmd), .elem_done(elem_done),
        .rld_sel(rld_sel), .rld_a(rld_a), .rld_b(rld_b),
        .status(status), .count(count), .done(done)
    );

    // behavioural reference model
    always @(posedge clk) begin
        if (rst) begin
            m_st = 0; m_cnt = 0; m_done = 0;
        end else begin
            m_done = 0;
            if (cmd_wr) begin
                if (cmd == 2'b00) m_st = 0;
                else if (cmd == 2'b10) begin
                    if (m_st == 1 || m_st == 3) m_st = 2;
                end else begin
                    if (m_st == 0) m_cnt = rld_sel ? int'(rld_b) : int'(rld_a);
                    m_st = int'(cmd);
                end
            end else if (elem_done && (m_st == 1 || m_st == 3)) begin
                if (m_cnt <= 1) begin
                    if (m_st == 3) m_cnt = rld_sel ? int'(rld_b) : int'(rld_a);
                    else begin m_cnt = 0; m_st = 0; m_done = 1; end
                end else m_cnt = m_cnt - 1;
            end
        end
    end

    task automatic check(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    always @(posedge clk) begin
        #1;
        cycles++;
        check(cur_req, "status", int'(status), m_st);
        check(cur_req, "count", int'(count), m_cnt);
        check(cur_req, "done", int'(done), m_done);
        if (cycles > 20000) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic step(input bit w, input logic [1:0] c, input bit e, input string t);
        cur_req = t;
        cmd_wr = w; cmd = c; elem_done = e;
        @(negedge clk);
        cmd_wr = 1'b0; elem_done = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        check("R1", "reset status", int'(status), 0);
        check("R1", "reset count", int'(count), 0);
        rst = 1'b0;
        rld_a = 16'd5; rld_b = 16'd9; rld_sel = 1'b0;
        step(0, 2'b00, 1, "R1");
        step(1, 2'b01, 0, "R3");
        check("R2", "start status", int'(status), 1);
        check("R3", "load from A", int'(count), 5);
        step(0, 2'b00, 1, "R4");
        step(0, 2'b00, 1, "R4");
        check("R4", "after two strobes", int'(count), 3);
        step(1, 2'b10, 0, "R7");
        for (int i = 0; i < 3; i++) step(0, 2'b00, 1, "R7");
        check("R7", "paused count", int'(count), 3);
        step(1, 2'b01, 0, "R8");
        check("R8", "resumed count", int'(count), 3);
        step(0, 2'b00, 1, "R5");
        step(0, 2'b00, 1, "R5");
        step(0, 2'b00, 1, "R5");
        check("R5", "done pulse", int'(done), 1);
        check("R5", "stopped", int'(status), 0);
        step(0, 2'b00, 0, "R5");
        check("R5", "done low again", int'(done), 0);
        rld_sel = 1'b1;
        step(1, 2'b11, 0, "R3");
        check("R3", "load from B", int'(count), 9);
        rld_b = 16'd4;
        for (int i = 0; i < 12; i++) step(0, 2'b00, 1, "R6");
        check("R6", "auto still running", int'(status), 3);
        step(1, 2'b01, 0, "R11");
        step(1, 2'b10, 1, "R10");
        step(1, 2'b11, 1, "R10");
        step(0, 2'b00, 1, "R4");
        step(1, 2'b00, 1, "R9");
        check("R9", "stop", int'(status), 0);
        for (int i = 0; i < 3; i++) step(0, 2'b00, 1, "R9");
        step(1, 2'b10, 0, "R7");
        check("R7", "pause while stopped", int'(status), 0);
        rld_sel = 1'b0; rld_a = 16'd0;
        step(1, 2'b01, 0, "R3");
        step(0, 2'b00, 1, "R5");
        check("R5", "zero count ends block", int'(done), 1);
        rld_a = 16'd1;
        step(1, 2'b11, 0, "R6");
        step(0, 2'b00, 1, "R6");
        step(0, 2'b00, 1, "R6");
        check("R6", "reload of one", int'(count), 1);
        step(0, 2'b00, 0, "R2");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule